// File: doc/BRIEF.md
# Rate-Selectable GF(2) Product Block Encoder

This block turns a serial stream of payload bits into 15-bit codewords. A rate select chooses how many bits make up each message. At the low rate a message is 7 bits long. At the high rate it is 11 bits long. Each completed message is multiplied over GF(2), without carries, by a fixed generator polynomial that belongs to the chosen rate. The low rate uses x^8 + x^7 + x^6 + x^4 + 1, which adds eight redundancy bits. The high rate uses x^4 + x + 1, which adds four. In both cases the product has degree at most 14, so it fits in a 15-bit codeword.

Bits enter one per cycle through a valid/ready handshake, and a regrouping stage collects them into messages. The product is formed by a pure XOR network and captured in an output register. That register presents the codeword through a second valid/ready handshake. The codeword is the full product of message and generator. It is not a systematic remainder, so every codeword divides evenly by its generator. The rate select is meant to be static, but a change is only picked up when a new message starts. A change made while a message is half collected therefore waits until the next message boundary.

Top module: `gf2_rate_encoder`

## Requirements
- R1: After reset, `cw_valid` is 0 and `in_ready` is 1.
- R2: With `rate_sel` = 0 at the start of a message, 7 accepted bits form the message, and `cw_data` is its GF(2) product with x^8+x^7+x^6+x^4+1 (0x1D1).
- R3: With `rate_sel` = 1 at the start of a message, 11 accepted bits form the message, and `cw_data` is its GF(2) product with x^4+x+1 (0x13).
- R4: The first accepted bit of a message is its highest-order coefficient (x^6 at the low rate, x^10 at the high rate). `cw_data[14]` is the x^14 coefficient and `cw_data[0]` is the constant term.
- R5: `cw_valid` is 1 in the cycle right after the final bit of a message is accepted.
- R6: While `cw_ready` stays 1, `in_ready` stays 1. A continuous input stream then yields one codeword for every 7 or 11 input cycles, and no codeword is lost.
- R7: While `cw_valid` = 1 and `cw_ready` = 0, `cw_data` and `cw_valid` hold their values, `in_ready` is 0, and no input bit is consumed.
- R8: The value of `rate_sel` is taken only when the first bit of a message is accepted. Changing it in the middle of a message does not change that message's length or generator.
- R9: Cycles in which `in_valid` = 0 consume no bit, and they leave the message under assembly unchanged.
- R10: Every presented codeword divides evenly by the generator of the rate it was built with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | 0: 7-bit messages; 1: 11-bit messages |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Block can take an input bit |
| in_bit | input | 1 | Serial payload bit |
| cw_valid | output | 1 | Codeword register holds a codeword |
| cw_ready | input | 1 | Consumer takes the codeword |
| cw_data | output | 15 | Codeword, bit 14 is the highest coefficient |

## Verification
The hardest situation to reach from the ports is a change of the rate select while a message is only partly collected. If this goes wrong, message boundaries drift and the damage shows up only in later codewords. The stimulus flips the select partway through words at both rates, then checks both that word and the next one against a bit-serial product computed in the bench. A second hard case is a held output that blocks the input while a bit is being offered. The bench holds off the consumer and keeps a bit on the input for several cycles. It then releases the consumer and sends a fresh word; any bit swallowed during the stall would misalign that word.

// File: rtl/gf2enc_pkg.sv
package gf2enc_pkg;

  localparam int CW_MAX  = 15;
  localparam int GEN_MAX = 9;

  typedef enum logic {
    RATE_LO = 1'b0,
    RATE_HI = 1'b1
  } rate_e;

  // Long division over GF(2); true when gen divides cw with no remainder.
  function automatic logic gf2_divides(input logic [CW_MAX-1:0] cw,
                                       input logic [GEN_MAX-1:0] gen,
                                       input int deg);
    logic [CW_MAX-1:0] r;
    r = cw;
    for (int i = CW_MAX - 1; i >= 0; i--) begin
      if (i >= deg && r[i]) r = r ^ (CW_MAX'(gen) << (i - deg));
    end
    return (r == '0);
  endfunction

endpackage

// File: rtl/enc_bit_packer.sv
module enc_bit_packer
  import gf2enc_pkg::*;
#(
  parameter int K_LO = 7,
  parameter int K_HI = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rate_sel,
  input  logic            in_valid,
  input  logic            in_ready,
  input  logic            in_bit,
  output logic            word_done,
  output rate_e           word_rate,
  output logic [K_HI-1:0] word_msg
);

  localparam int CNT_W = $clog2(K_HI);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(K_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(K_HI - 1);
  localparam logic [K_HI-1:0]  MASK_LO = K_HI'((1 << K_LO) - 1);

  logic [CNT_W-1:0] cnt_q;
  rate_e            rate_q;
  logic [K_HI-2:0]  shreg_q;
  logic             accept;
  rate_e            eff_rate;
  logic [CNT_W-1:0] last_idx;

  assign accept    = in_valid && in_ready;
  assign eff_rate  = (cnt_q == '0) ? rate_e'(rate_sel) : rate_q;
  assign last_idx  = (eff_rate == RATE_HI) ? LAST_HI : LAST_LO;
  assign word_done = accept && (cnt_q == last_idx);
  assign word_rate = eff_rate;
  assign word_msg  = {shreg_q, in_bit} & ((eff_rate == RATE_HI) ? {K_HI{1'b1}} : MASK_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rate_q  <= RATE_LO;
      shreg_q <= '0;
    end else if (accept) begin
      if (cnt_q == '0) rate_q <= rate_e'(rate_sel);
      if (word_done) begin
        cnt_q   <= '0;
        shreg_q <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= {shreg_q[K_HI-3:0], in_bit};
      end
    end
  end

  // R8
  rate_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(rate_q));

  // R2
  lo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == RATE_LO && cnt_q != '0) |-> (cnt_q <= LAST_LO));

  // R3
  hi_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_HI);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cnt_q) && $stable(shreg_q)));

endmodule

// File: rtl/gf2_poly_mul.sv
module gf2_poly_mul #(
  parameter int               K     = 7,
  parameter int               DEG   = 8,
  parameter int               GEN_W = 9,
  parameter logic [GEN_W-1:0] GEN   = 9'h1D1
) (
  input  logic [K-1:0]     msg,
  output logic [K+DEG-1:0] prod
);

  // Carry-less product: each generator tap XORs a shifted copy of msg.
  always_comb begin
    prod = '0;
    for (int i = 0; i < K; i++) begin
      for (int j = 0; j <= DEG; j++) begin
        if (GEN[j]) prod[i+j] = prod[i+j] ^ msg[i];
      end
    end
  end

endmodule

// File: rtl/cw_out_stage.sv
module cw_out_stage
  import gf2enc_pkg::*;
#(
  parameter int               CW_W   = 15,
  parameter int               GEN_W  = 9,
  parameter int               DEG_LO = 8,
  parameter int               DEG_HI = 4,
  parameter logic [GEN_W-1:0] GEN_LO = 9'h1D1,
  parameter logic [GEN_W-1:0] GEN_HI = 9'h013
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CW_W-1:0] load_data,
  input  rate_e           load_rate,
  input  logic            cw_ready,
  output logic            cw_valid,
  output logic [CW_W-1:0] cw_data,
  output logic            out_free
);

  rate_e held_rate;

  assign out_free = !cw_valid || cw_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_valid  <= 1'b0;
      cw_data   <= '0;
      held_rate <= RATE_LO;
    end else if (load) begin
      cw_valid  <= 1'b1;
      cw_data   <= load_data;
      held_rate <= load_rate;
    end else if (cw_ready) begin
      cw_valid  <= 1'b0;
    end
  end

  // R7
  cw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_data)));

  // R10
  cw_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> gf2_divides(CW_MAX'(cw_data),
                             GEN_MAX'((held_rate == RATE_HI) ? GEN_HI : GEN_LO),
                             (held_rate == RATE_HI) ? DEG_HI : DEG_LO));

endmodule

// File: rtl/gf2_rate_encoder.sv
module gf2_rate_encoder
  import gf2enc_pkg::*;
#(
  parameter int   K_LO   = 7,
  parameter int   K_HI   = 11,
  parameter int   DEG_LO = 8,
  parameter int   DEG_HI = 4,
  parameter logic [DEG_LO:0] GEN_LO = 9'h1D1,
  parameter logic [DEG_LO:0] GEN_HI = 9'h013
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rate_sel,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_bit,
  output logic                   cw_valid,
  input  logic                   cw_ready,
  output logic [K_LO+DEG_LO-1:0] cw_data
);

  localparam int CW_W  = K_LO + DEG_LO;
  localparam int GEN_W = DEG_LO + 1;
  localparam int NRATE = 2;

  logic            word_done;
  rate_e           word_rate;
  logic [K_HI-1:0] word_msg;
  logic [CW_W-1:0] prod_arr [NRATE];
  logic            out_free;

  assign in_ready = out_free;

  enc_bit_packer #(.K_LO(K_LO), .K_HI(K_HI)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_bit   (in_bit),
    .word_done(word_done),
    .word_rate(word_rate),
    .word_msg (word_msg)
  );

  for (genvar g = 0; g < NRATE; g++) begin : g_mul
    localparam int               KG = (g == 0) ? K_LO : K_HI;
    localparam int               DG = (g == 0) ? DEG_LO : DEG_HI;
    localparam logic [GEN_W-1:0] GG = (g == 0) ? GEN_LO : GEN_HI;
    gf2_poly_mul #(.K(KG), .DEG(DG), .GEN_W(GEN_W), .GEN(GG)) u_mul (
      .msg (word_msg[KG-1:0]),
      .prod(prod_arr[g])
    );
  end

  cw_out_stage #(
    .CW_W(CW_W), .GEN_W(GEN_W), .DEG_LO(DEG_LO), .DEG_HI(DEG_HI),
    .GEN_LO(GEN_LO), .GEN_HI(GEN_HI)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (word_done),
    .load_data(prod_arr[word_rate == RATE_HI ? 1 : 0]),
    .load_rate(word_rate),
    .cw_ready (cw_ready),
    .cw_valid (cw_valid),
    .cw_data  (cw_data),
    .out_free (out_free)
  );

  // R5
  cw_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> cw_valid);

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |-> !in_ready);

  // R6
  free_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_ready |-> in_ready);

endmodule

// File: tb/gf2_rate_encoder_bench.sv
`timescale 1ns/1ps
module gf2_rate_encoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        cw_ready = 1'b1;
  logic        in_ready;
  logic        cw_valid;
  logic [14:0] cw_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [14:0] exp_q [0:511];
  string       tag_q [0:511];
  int wr = 0;
  int rd = 0;
  bit tp_mode = 1'b0;
  int tp_stalls = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  gf2_rate_encoder u_gf2_rate_encoder (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .cw_valid(cw_valid),
    .cw_ready(cw_ready), .cw_data(cw_data)
  );

  // stimulus: rate, message (11 bits), expected codeword
  localparam logic [26:0] VEC [7] = '{
    {1'b0, 11'h001, 15'h01D1},
    {1'b0, 11'h040, 15'h7440},
    {1'b0, 11'h07F, 15'h58CF},
    {1'b1, 11'h001, 15'h0013},
    {1'b1, 11'h400, 15'h4C00},
    {1'b1, 11'h7FF, 15'h77F1},
    {1'b1, 11'h000, 15'h0000}
  };

  function automatic logic [14:0] ref_cw(input logic rate, input logic [10:0] msg);
    logic [14:0] acc;
    logic [8:0]  gen;
    int          k;
    acc = '0;
    gen = rate ? 9'h013 : 9'h1D1;
    k   = rate ? 11 : 7;
    for (int i = k - 1; i >= 0; i--) acc = (acc << 1) ^ (msg[i] ? 15'(gen) : 15'h0);
    return acc;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_bit(input logic b);
    bit ok;
    int waits;
    waits = 0;
    in_valid = 1'b1;
    in_bit   = b;
    do begin
      @(negedge clk);
      ok = in_ready;
      if (!ok) waits++;
      @(posedge clk);
      #1;
    end while (!ok);
    in_valid = 1'b0;
    if (tp_mode && waits != 0) tp_stalls++;
  endtask

  task automatic send_word(input logic rate, input logic [10:0] msg, input logic [14:0] exp,
                           input string tag, input int flip_at, input int gap);
    int k;
    k = rate ? 11 : 7;
    rate_sel = rate;
    exp_q[wr] = exp;
    tag_q[wr] = tag;
    wr++;
    for (int i = k - 1; i >= 0; i--) begin
      if (flip_at > 0 && (k - 1 - i) == flip_at) rate_sel = ~rate;
      push_bit(msg[i]);
      if (gap > 0 && i > 0) repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cw_valid && cw_ready) begin
      if (rd < wr) check(tag_q[rd], 32'(cw_data), 32'(exp_q[rd]));
      else check("R6 extra codeword", 32'(cw_data), 32'h0);
      rd++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 cw_valid in reset", 32'(cw_valid), 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready", 32'(in_ready), 32'h1);
    check("R1 cw_valid", 32'(cw_valid), 32'h0);
    @(posedge clk); #1;

    // table walk (R2, R3, R4)
    for (int v = 0; v < 7; v++) begin
      logic [26:0] e;
      e = VEC[v];
      send_word(e[26], e[25:15], e[14:0],
                (v == 1 || v == 4) ? "R4 order" : (e[26] ? "R3 rate hi" : "R2 rate lo"), 0, 0);
    end

    // R5 latency
    send_word(1'b0, 11'h05A, ref_cw(1'b0, 11'h05A), "R2 latency word", 0, 0);
    @(negedge clk);
    check("R5 cw_valid after last bit", 32'(cw_valid), 32'h1);
    @(posedge clk); #1;

    // R6 back-to-back random words at both rates
    tp_mode = 1'b1;
    for (int w = 0; w < 80; w++) begin
      logic r;
      logic [10:0] m;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr[3] ^ w[0];
      m = r ? lfsr[10:0] : {4'h0, lfsr[6:0]};
      send_word(r, m, ref_cw(r, m), r ? "R3 random" : "R2 random", 0, 0);
    end
    tp_mode = 1'b0;
    check("R6 input stalls with ready consumer", 32'(tp_stalls), 32'h0);

    // R7 stalled output blocks input
    repeat (2) begin @(posedge clk); #1; end
    cw_ready = 1'b0;
    send_word(1'b1, 11'h2B5, ref_cw(1'b1, 11'h2B5), "R7 held word", 0, 0);
    in_valid = 1'b1;
    in_bit   = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R7 in_ready low", 32'(in_ready), 32'h0);
      check("R7 cw_data held", 32'(cw_data), 32'(ref_cw(1'b1, 11'h2B5)));
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    cw_ready = 1'b1;
    send_word(1'b0, 11'h033, ref_cw(1'b0, 11'h033), "R7 no bit swallowed", 0, 0);

    // R8 mid-word rate changes
    send_word(1'b0, 11'h06C, ref_cw(1'b0, 11'h06C), "R8 lo word, select flipped", 3, 0);
    send_word(1'b1, 11'h5A3, ref_cw(1'b1, 11'h5A3), "R8 hi word after flip", 0, 0);
    send_word(1'b1, 11'h1C7, ref_cw(1'b1, 11'h1C7), "R8 hi word, select flipped", 5, 0);
    send_word(1'b0, 11'h041, ref_cw(1'b0, 11'h041), "R8 lo word after flip", 0, 0);

    // R9 idle gaps between bits
    send_word(1'b1, 11'h6E9, ref_cw(1'b1, 11'h6E9), "R9 gaps hi", 0, 3);
    send_word(1'b0, 11'h015, ref_cw(1'b0, 11'h015), "R9 gaps lo", 0, 2);

    repeat (5) begin @(posedge clk); #1; end
    check("R6 all codewords delivered", 32'(rd), 32'(wr));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule